// File: doc/BRIEF.md
# Tone Frequency Band Classifier

This block decides whether a squared-up audio tone belongs to the low band (roughly 300 to 660 Hz) or the high band (roughly 900 to 2150 Hz), so that a downstream frequency-measurement stage knows which measurement period to use. It runs from the fast system clock. It counts rising edges of the digital tone input over fixed evaluation windows of `WIN_CYCLES` clocks, which is 9.8 ms at 3.579545 MHz by default. At the end of each window it compares the count against two edge-count ranges.

The band decision has hysteresis. A window whose count falls in the low range moves the block to the low band. A window whose count falls in the high range moves it to the high band. Any other window changes nothing: too few edges, counts in the gap between the bands, and counts above the high range all leave the band as it was. When the latched band toggles, a one-cycle pulse tells the measurement timer to abandon its current count. A low decoder-enable holds the window timer and the edge count in reset and freezes the band.

Top module: `tone_band_classifier`

## Requirements
- R1: After reset, band_o is 0, band_valid_o is 0 and band_chg_o is 0.
- R2: Rising edges of tone_i are counted over each window of WIN_CYCLES enabled clocks. A total from LO_MIN_EDGES to LO_MAX_EDGES (default 3 to 6) is low-band evidence. A total from HI_MIN_EDGES to HI_MAX_EDGES (default 9 to 21) is high-band evidence.
- R3: band_valid_o stays 0 until the first window that ends with low or high evidence, which is no sooner than WIN_CYCLES clocks after enable. From then on it stays 1 until reset.
- R4: Evidence for the band already held leaves band_o unchanged and produces no pulse.
- R5: A window total strictly between LO_MAX_EDGES and HI_MIN_EDGES has no effect on band_o, band_valid_o or band_chg_o.
- R6: A window total below LO_MIN_EDGES, or above HI_MAX_EDGES, has no effect on band_o or band_chg_o.
- R7: band_chg_o is high for exactly one clock, in the cycle in which band_o first shows its new value, and is never high at any other time.
- R8: While en_i is 0, the window timer and the edge count are held at zero and band_o is frozen. After en_i returns to 1, the next decision is made only after a full WIN_CYCLES window.
- R9: band_o changes only on the clock edge that closes an evaluation window.
- R10: band_o uses the encoding 1 = high band and 0 = low band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tone_i | input | 1 | Squared tone input (asynchronous) |
| en_i | input | 1 | Decoder enable; low holds the window and count in reset |
| band_o | output | 1 | Latched band, 1 = high, 0 = low |
| band_valid_o | output | 1 | A band has been chosen since reset |
| band_chg_o | output | 1 | One-cycle pulse when band_o toggles |

## Verification
Each decision is due on the clock that closes a window. That edge comes WIN_CYCLES enabled clocks after the window opened. Because tone_i passes through a two-flop synchronizer and an edge flop, an input edge reaches the count about three clocks late, so an edge can slip into the next window. The bench therefore picks tone periods whose edge counts stay inside one class even when shifted by one edge. It restarts the window with a short enable drop at each change of scenario, and it samples band_o at negedge, at least 20 clocks before or after the expected boundary. band_chg_o is monitored on every cycle, and the bench records both the number of pulses and the longest run of high cycles.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  typedef enum logic {
    BAND_LO = 1'b0,
    BAND_HI = 1'b1
  } band_e;
endpackage

// File: rtl/tbc_window_timer.sv
module tbc_window_timer #(
  parameter int unsigned WIN_CYCLES = 35078,
  localparam int unsigned CW = $clog2(WIN_CYCLES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic win_end_o
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign win_end_o = en_i && (cnt_q == LAST);

  assert_timer_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
  assert_timer_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/tbc_edge_counter.sv
module tbc_edge_counter #(
  parameter int unsigned HI_MAX_EDGES = 21,
  localparam int unsigned EW = $clog2(HI_MAX_EDGES + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tone_i,
  input  logic          en_i,
  input  logic          win_end_i,
  output logic [EW:0]   total_o
);
  localparam logic [EW-1:0] SAT = '1;

  logic [2:0]    sync_q;
  logic          rise;
  logic [EW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tone_i};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || win_end_i) cnt_q <= '0;
    else if (rise && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  // edge arriving on the closing cycle still belongs to this window
  assign total_o = en_i ? ({1'b0, cnt_q} + {{EW{1'b0}}, rise}) : '0;

  assert_count_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
  assert_count_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_i |=> (cnt_q == '0));
endmodule

// File: rtl/tbc_band_latch.sv
module tbc_band_latch
  import tbc_pkg::*;
#(
  parameter int unsigned LO_MIN_EDGES = 3,
  parameter int unsigned LO_MAX_EDGES = 6,
  parameter int unsigned HI_MIN_EDGES = 9,
  parameter int unsigned HI_MAX_EDGES = 21,
  localparam int unsigned EW = $clog2(HI_MAX_EDGES + 2)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        win_end_i,
  input  logic [EW:0] total_i,
  output band_e       band_o,
  output logic        valid_o,
  output logic        chg_o
);
  logic  lo_ev, hi_ev;
  band_e band_q;
  logic  valid_q, chg_q;

  assign lo_ev = (32'(total_i) >= LO_MIN_EDGES) && (32'(total_i) <= LO_MAX_EDGES);
  assign hi_ev = (32'(total_i) >= HI_MIN_EDGES) && (32'(total_i) <= HI_MAX_EDGES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      band_q  <= BAND_LO;
      valid_q <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (win_end_i) begin
        if (hi_ev) band_q <= BAND_HI;
        else if (lo_ev) band_q <= BAND_LO;
        if (lo_ev || hi_ev) valid_q <= 1'b1;
        chg_q <= (hi_ev && band_q == BAND_LO) || (lo_ev && band_q == BAND_HI);
      end
    end
  end

  assign band_o  = band_q;
  assign valid_o = valid_q;
  assign chg_o   = chg_q;

  assert_pulse_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |=> !chg_q);
  assert_pulse_on_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (band_q != $past(band_q)) |-> chg_q);
  assert_band_at_boundary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (band_q != $past(band_q)) |-> $past(win_end_i));
  assert_valid_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q);
endmodule

// File: rtl/tone_band_classifier.sv
module tone_band_classifier
  import tbc_pkg::*;
#(
  parameter int unsigned WIN_CYCLES   = 35078,
  parameter int unsigned LO_MIN_EDGES = 3,
  parameter int unsigned LO_MAX_EDGES = 6,
  parameter int unsigned HI_MIN_EDGES = 9,
  parameter int unsigned HI_MAX_EDGES = 21
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tone_i,
  input  logic en_i,
  output logic band_o,
  output logic band_valid_o,
  output logic band_chg_o
);
  localparam int unsigned EW = $clog2(HI_MAX_EDGES + 2);

  logic        win_end;
  logic [EW:0] total;
  band_e       band;

  tbc_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk_i, .rst_ni, .en_i, .win_end_o(win_end)
  );

  tbc_edge_counter #(.HI_MAX_EDGES(HI_MAX_EDGES)) u_edges (
    .clk_i, .rst_ni, .tone_i, .en_i, .win_end_i(win_end), .total_o(total)
  );

  tbc_band_latch #(
    .LO_MIN_EDGES(LO_MIN_EDGES), .LO_MAX_EDGES(LO_MAX_EDGES),
    .HI_MIN_EDGES(HI_MIN_EDGES), .HI_MAX_EDGES(HI_MAX_EDGES)
  ) u_latch (
    .clk_i, .rst_ni, .win_end_i(win_end), .total_i(total),
    .band_o(band), .valid_o(band_valid_o), .chg_o(band_chg_o)
  );

  assign band_o = band;

  initial begin
    assert_bands_ordered_R5: assert (LO_MIN_EDGES <= LO_MAX_EDGES &&
                                     LO_MAX_EDGES < HI_MIN_EDGES &&
                                     HI_MIN_EDGES <= HI_MAX_EDGES);
  end
endmodule

// File: tb/tone_band_classifier_test.sv
`timescale 1ns/1ps
module tone_band_classifier_test;
  localparam int WIN = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tone = 1'b0;
  logic en = 1'b0;
  logic band, valid, chg;

  int half = 0;
  int n_checks = 0;
  int n_fail = 0;
  int pulses = 0;
  int run = 0;
  int max_run = 0;

  always #2.5 clk = ~clk;

  tone_band_classifier #(
    .WIN_CYCLES(WIN), .LO_MIN_EDGES(3), .LO_MAX_EDGES(6),
    .HI_MIN_EDGES(9), .HI_MAX_EDGES(21)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .tone_i(tone), .en_i(en),
    .band_o(band), .band_valid_o(valid), .band_chg_o(chg)
  );

  initial begin
    forever begin
      if (half == 0) begin
        @(negedge clk);
        tone = 1'b0;
      end else begin
        repeat (half) @(negedge clk);
        tone = ~tone;
      end
    end
  end

  always @(negedge clk) begin
    if (chg) begin
      pulses <= pulses + 1;
      run <= run + 1;
      if (run + 1 > max_run) max_run <= run + 1;
    end else run <= 0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // restart evaluation window with a new tone
  task automatic restart(input int h);
    @(negedge clk);
    en = 1'b0;
    half = h;
    wait_cyc(4);
    en = 1'b1;
  endtask

  task automatic t_reset();
    wait_cyc(3);
    check(band == 1'b0, "R1 band", band, 0);
    check(valid == 1'b0, "R1 valid", valid, 0);
    check(chg == 1'b0, "R1 chg", chg, 0);
    rst_n = 1'b1;
    wait_cyc(2);
  endtask

  task automatic t_first_window();
    restart(20);
    wait_cyc(WIN - 20);
    check(valid == 1'b0, "R3 early valid", valid, 0);
    wait_cyc(40);
    check(valid == 1'b1, "R3 valid after window", valid, 1);
    check(band == 1'b0, "R2 low band", band, 0);
    check(pulses == 0, "R4 no pulse on low", pulses, 0);
  endtask

  task automatic t_low_hold();
    wait_cyc(3 * WIN);
    check(band == 1'b0, "R4 low held", band, 0);
    check(pulses == 0, "R4 no pulse on repeat", pulses, 0);
  endtask

  task automatic t_to_high();
    restart(7);
    wait_cyc(WIN + 20);
    check(band == 1'b1, "R10 high band is 1", band, 1);
    check(pulses == 1, "R7 one pulse", pulses, 1);
    check(max_run == 1, "R7 pulse width", max_run, 1);
  endtask

  task automatic t_dead_zone();
    restart(13);
    wait_cyc(4 * WIN);
    check(band == 1'b1, "R5 dead zone band", band, 1);
    check(pulses == 1, "R5 dead zone pulse", pulses, 1);
    check(valid == 1'b1, "R5 dead zone valid", valid, 1);
  endtask

  task automatic t_out_of_range();
    restart(50);
    wait_cyc(3 * WIN);
    check(band == 1'b1, "R6 sparse band", band, 1);
    restart(3);
    wait_cyc(3 * WIN);
    check(band == 1'b1, "R6 over-range band", band, 1);
    restart(0);
    wait_cyc(2 * WIN);
    check(band == 1'b1, "R6 silent band", band, 1);
    check(pulses == 1, "R6 no pulse", pulses, 1);
  endtask

  task automatic t_to_low();
    restart(20);
    wait_cyc(WIN + 20);
    check(band == 1'b0, "R2 back to low", band, 0);
    check(pulses == 2, "R7 second pulse", pulses, 2);
    check(max_run == 1, "R7 pulse width again", max_run, 1);
  endtask

  task automatic t_disable();
    @(negedge clk);
    en = 1'b0;
    half = 7;
    wait_cyc(5 * WIN);
    check(band == 1'b0, "R8 frozen while off", band, 0);
    check(pulses == 2, "R8 no pulse while off", pulses, 2);
    en = 1'b1;
    wait_cyc(WIN - 20);
    check(band == 1'b0, "R8 full window after enable", band, 0);
    wait_cyc(40);
    check(band == 1'b1, "R8 decision after window", band, 1);
    check(pulses == 3, "R7 pulse after enable", pulses, 3);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_first_window();
        t_low_hold();
        t_to_high();
        t_dead_zone();
        t_out_of_range();
        t_to_low();
        t_disable();
      end
      begin
        wait_cyc(150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
      end
    join_any
    summary();
  end
endmodule